// File: doc/BRIEF.md
# Serial Stereo Level Register

This block is the digital control front end of a two-channel audio level controller. A host writes a 16-bit word over a three-wire serial port made up of a serial clock, an active-low select and a data input. The first byte of the word sets the right channel and the second byte sets the left channel. The block keeps a shift register and a held register. The held word drives two 8-bit level codes, two signed half-decibel level values and two per-channel mute flags.

While a word shifts in, the block shifts the previously held word out of the serial data output. A host can read back the current setting this way. Several of these blocks can also be chained, each one's output feeding the next one's input. A new setting takes effect only when the select line returns high, so both channels change in the same cycle.

All serial pins are oversampled in the system clock domain. A separate active-low mute pin is synchronized and debounced, and it mutes both channels once it has stayed low for a programmable number of cycles.

Top module: `stereo_level_port`

## Requirements
- R1: A frame is sent most significant bit first. Once the held register is loaded, the first 8 bits received appear on `code_right` and the last 8 bits appear on `code_left`.
- R2: Data is sampled on rising serial clock edges only while select is low. Clock and data activity while select is high changes neither the codes nor the word read back.
- R3: The held codes change only when select rises. Both codes take their new values in the same cycle, and during a frame they keep their old values.
- R4: When select falls, `ser_dout` presents bit 15 of the held word. Each falling serial clock edge then presents the next lower bit. Bits beyond the sixteenth are the bits received at the start of the same frame, delayed by 16 clocks, so the output can feed a downstream device.
- R5: `ser_dout` is high-impedance whenever the synchronized select is high.
- R6: If a frame has more than 16 clocks, the held register takes the last 16 bits shifted in.
- R7: After reset both codes are zero and both mute flags are set.
- R8: A channel code of zero sets that channel's mute flag. It does not set the other channel's flag.
- R9: The level output is code minus UNITY_CODE as a signed 9-bit count of 0.5 dB steps. With the default of 192, code 255 gives +63, code 192 gives 0 and code 1 gives -191.
- R10: Both mute flags are set once `mute_n` has been low for MUTE_HOLD_CYCLES cycles after synchronization. A shorter low pulse has no effect. The flags follow the codes again after the pin returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock |
| ser_cs_n | input | 1 | Active-low frame select |
| ser_din | input | 1 | Serial data in |
| ser_dout | output | 1 | Serial data out, high-impedance when deselected |
| mute_n | input | 1 | Active-low mute request pin |
| code_right | output | 8 | Held right-channel code |
| code_left | output | 8 | Held left-channel code |
| level_right | output | 9 | Right level, signed half-dB steps |
| level_left | output | 9 | Left level, signed half-dB steps |
| mute_right | output | 1 | Right channel muted |
| mute_left | output | 1 | Left channel muted |

## Verification
The bench builds the block with two synchronizer stages and a mute hold of 12 cycles instead of a full 2 ms count. With these values, short and long mute pulses each finish within a few dozen cycles. The serial bit period is eight system clocks, which leaves room for the synchronizer latency, so readback bits can be sampled just before each rising edge. A 24-clock frame covers the daisy-chain delay and the over-length frame rule, and the code values 0, 1, 192 and 255 cover the ends of the level range.

// File: rtl/slp_pkg.sv
package slp_pkg;
   typedef enum logic [1:0] {
      SER_IDLE,
      SER_RISE,
      SER_FALL
   } ser_evt_e;

   function automatic ser_evt_e classify_edge(input logic prev, input logic now);
      if (!prev && now) return SER_RISE;
      if (prev && !now) return SER_FALL;
      return SER_IDLE;
   endfunction
endpackage

// File: rtl/slp_bit_sync.sv
module slp_bit_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("slp_bit_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain[i] <= RESET_VAL;
         end else begin
            if (i == 0) chain[i] <= d;
            else        chain[i] <= chain[(i == 0) ? 0 : i-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/slp_frame_shifter.sv
module slp_frame_shifter
   import slp_pkg::*;
#(
   parameter int CODE_BITS = 8,
   localparam int FRAME_BITS = 2 * CODE_BITS
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sclk_s,
   input  logic                  cs_n_s,
   input  logic                  din_s,
   output logic [FRAME_BITS-1:0] held_word,
   output logic                  dout_bit
);
   if (CODE_BITS < 1) begin : g_bad_code
      $error("slp_frame_shifter: CODE_BITS must be positive");
   end

   logic                  cs_prev;
   logic                  sclk_prev;
   logic [FRAME_BITS-1:0] shreg;
   logic                  cs_fall;
   logic                  cs_rise;
   ser_evt_e              evt;

   assign cs_fall = cs_prev & ~cs_n_s;
   assign cs_rise = ~cs_prev & cs_n_s;
   assign evt     = classify_edge(sclk_prev, sclk_s);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_prev   <= 1'b1;
         sclk_prev <= 1'b0;
         shreg     <= '0;
         held_word <= '0;
         dout_bit  <= 1'b0;
      end else begin
         cs_prev   <= cs_n_s;
         sclk_prev <= sclk_s;
         if (cs_fall) begin
            shreg    <= held_word;
            dout_bit <= held_word[FRAME_BITS-1];
         end else if (!cs_n_s) begin
            case (evt)
               SER_RISE: shreg    <= {shreg[FRAME_BITS-2:0], din_s};
               SER_FALL: dout_bit <= shreg[FRAME_BITS-1];
               default:  ;
            endcase
         end
         if (cs_rise) held_word <= shreg;
      end
   end

   // R2: a rising edge inside a frame takes the sampled bit into the low end
   p_shift_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n_s && !cs_fall && evt == SER_RISE) |=> shreg[0] == $past(din_s));

   // R3: the held word moves only on the select rise
   p_hold_between_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_rise) |=> $stable(held_word));
endmodule

// File: rtl/slp_mute_debounce.sv
module slp_mute_debounce #(
   parameter int HOLD_CYCLES = 100000,
   localparam int CNT_W = $clog2(HOLD_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n_s,
   output logic muted
);
   if (HOLD_CYCLES < 1) begin : g_bad_hold
      $error("slp_mute_debounce: HOLD_CYCLES must be at least 1");
   end

   logic [CNT_W-1:0] low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt <= '0;
         muted   <= 1'b0;
      end else if (pin_n_s) begin
         low_cnt <= '0;
         muted   <= 1'b0;
      end else begin
         if (low_cnt != CNT_W'(HOLD_CYCLES)) low_cnt <= low_cnt + 1'b1;
         muted <= (low_cnt == CNT_W'(HOLD_CYCLES));
      end
   end

   // R10: a high pin clears the mute on the next cycle
   p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      pin_n_s |=> !muted);

   // R10: mute only starts while the pin is held low
   p_start_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(muted) |-> $past(!pin_n_s));
endmodule

// File: rtl/slp_chan_decode.sv
module slp_chan_decode #(
   parameter int CODE_BITS  = 8,
   parameter int UNITY_CODE = 192,
   localparam int LVL_W = CODE_BITS + 1
) (
   input  logic [CODE_BITS-1:0] code,
   input  logic                 pin_muted,
   output logic [LVL_W-1:0]     level,
   output logic                 muted
);
   if (UNITY_CODE < 1 || UNITY_CODE >= (1 << CODE_BITS)) begin : g_bad_unity
      $error("slp_chan_decode: UNITY_CODE out of code range");
   end

   logic code_zero;

   always_comb begin
      code_zero = (code == '0);
      level     = LVL_W'({1'b0, code}) - LVL_W'(UNITY_CODE);
      muted     = code_zero | pin_muted;
   end
endmodule

// File: rtl/stereo_level_port.sv
module stereo_level_port #(
   parameter int CODE_BITS        = 8,
   parameter int UNITY_CODE       = 192,
   parameter int SYNC_STAGES      = 2,
   parameter int MUTE_HOLD_CYCLES = 100000,
   localparam int NUM_CH     = 2,
   localparam int FRAME_BITS = NUM_CH * CODE_BITS,
   localparam int LVL_W      = CODE_BITS + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ser_clk,
   input  logic                 ser_cs_n,
   input  logic                 ser_din,
   output logic                 ser_dout,
   input  logic                 mute_n,
   output logic [CODE_BITS-1:0] code_right,
   output logic [CODE_BITS-1:0] code_left,
   output logic [LVL_W-1:0]     level_right,
   output logic [LVL_W-1:0]     level_left,
   output logic                 mute_right,
   output logic                 mute_left
);
   logic sclk_s, cs_n_s, din_s, mute_n_s;
   logic pin_muted;
   logic dout_bit;
   logic [FRAME_BITS-1:0] held_word;
   logic [CODE_BITS-1:0]  ch_code  [NUM_CH];
   logic [LVL_W-1:0]      ch_level [NUM_CH];
   logic                  ch_muted [NUM_CH];

   slp_bit_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_sclk (
      .clk(clk), .rst_n(rst_n), .d(ser_clk), .q(sclk_s));
   slp_bit_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_cs (
      .clk(clk), .rst_n(rst_n), .d(ser_cs_n), .q(cs_n_s));
   slp_bit_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_din (
      .clk(clk), .rst_n(rst_n), .d(ser_din), .q(din_s));
   slp_bit_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_mute (
      .clk(clk), .rst_n(rst_n), .d(mute_n), .q(mute_n_s));

   slp_frame_shifter #(.CODE_BITS(CODE_BITS)) u_shifter (
      .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .cs_n_s(cs_n_s),
      .din_s(din_s), .held_word(held_word), .dout_bit(dout_bit));

   slp_mute_debounce #(.HOLD_CYCLES(MUTE_HOLD_CYCLES)) u_debounce (
      .clk(clk), .rst_n(rst_n), .pin_n_s(mute_n_s), .muted(pin_muted));

   // channel 0 is the first byte on the wire (right), held in the upper bits
   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      assign ch_code[c] = held_word[(NUM_CH-1-c)*CODE_BITS +: CODE_BITS];
      slp_chan_decode #(.CODE_BITS(CODE_BITS), .UNITY_CODE(UNITY_CODE)) u_dec (
         .code(ch_code[c]), .pin_muted(pin_muted),
         .level(ch_level[c]), .muted(ch_muted[c]));
   end

   assign code_right  = ch_code[0];
   assign code_left   = ch_code[1];
   assign level_right = ch_level[0];
   assign level_left  = ch_level[1];
   assign mute_right  = ch_muted[0];
   assign mute_left   = ch_muted[1];
   assign ser_dout    = cs_n_s ? 1'bz : dout_bit;

   // R3: with select high for two cycles both codes stay put
   p_codes_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n_s && $past(cs_n_s)) |=> ($stable(code_right) && $stable(code_left)));

   // R8: a zero right code always shows as muted
   p_zero_mutes_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (code_right == '0) |-> mute_right);

   // R8: a nonzero left code without the pin mute is not muted
   p_nonzero_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (code_left != '0 && !pin_muted) |-> !mute_left);

   // R9: the unity code reads as zero level
   p_unity_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (code_left == CODE_BITS'(UNITY_CODE)) |-> (level_left == '0));
endmodule

// File: tb/stereo_level_port_tb.sv
module stereo_level_port_tb;
   localparam int CLK_PERIOD = 10;
   localparam int HOLD       = 12;
   localparam int HALF_BIT   = 4;

   typedef struct packed {
      logic [15:0]       word;
      logic signed [8:0] lr;
      logic signed [8:0] ll;
      logic              mr;
      logic              ml;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{16'hC0C0,  9'sd0,    9'sd0,   1'b0, 1'b0},
      '{16'hFF01,  9'sd63,  -9'sd191, 1'b0, 1'b0},
      '{16'h00C0, -9'sd192,  9'sd0,   1'b1, 1'b0},
      '{16'hC100,  9'sd1,   -9'sd192, 1'b0, 1'b1},
      '{16'h0000, -9'sd192, -9'sd192, 1'b1, 1'b1},
      '{16'h7F80, -9'sd65,  -9'sd64,  1'b0, 1'b0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_cs_n = 1'b1, ser_din = 1'b0, mute_n = 1'b1;
   wire  ser_dout;
   logic [7:0] code_right, code_left;
   logic [8:0] level_right, level_left;
   logic mute_right, mute_left;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   stereo_level_port #(.SYNC_STAGES(2), .MUTE_HOLD_CYCLES(HOLD)) u_dut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_cs_n(ser_cs_n),
      .ser_din(ser_din), .ser_dout(ser_dout), .mute_n(mute_n),
      .code_right(code_right), .code_left(code_left),
      .level_right(level_right), .level_left(level_left),
      .mute_right(mute_right), .mute_left(mute_left));

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic send_frame(input logic [31:0] data, input int nbits,
                             output logic [31:0] rb, output logic mid_ok);
      rb = '0;
      mid_ok = 1'b1;
      ser_cs_n = 1'b0;
      wait_clk(6);
      for (int b = 0; b < nbits; b++) begin
         ser_din = data[nbits-1-b];
         wait_clk(HALF_BIT);
         rb[nbits-1-b] = (ser_dout === 1'b1);
         ser_clk = 1'b1;
         wait_clk(HALF_BIT);
         ser_clk = 1'b0;
      end
      wait_clk(HALF_BIT);
      ser_cs_n = 1'b1;
      wait_clk(6);
   endtask

   initial begin
      logic [31:0] rb;
      logic mid;
      logic [15:0] prev;
      rst_n = 1'b0;
      wait_clk(3);
      rst_n = 1'b1;
      wait_clk(2);

      // R7 reset state, R5 high-impedance when deselected
      check("R7 code_right", code_right, 0);
      check("R7 code_left", code_left, 0);
      check("R7 mute_right", mute_right, 1);
      check("R7 mute_left", mute_left, 1);
      check("R5 dout z", int'(ser_dout === 1'bz), 1);

      // table walk: R1 R3 R4 R8 R9
      prev = 16'h0000;
      foreach (VECS[k]) begin
         send_frame({16'h0, VECS[k].word}, 16, rb, mid);
         check("R4 readback", rb[15:0], prev);
         check("R1 code_right", code_right, VECS[k].word[15:8]);
         check("R1 code_left", code_left, VECS[k].word[7:0]);
         check("R9 level_right", $signed(level_right), VECS[k].lr);
         check("R9 level_left", $signed(level_left), VECS[k].ll);
         check("R8 mute_right", mute_right, VECS[k].mr);
         check("R8 mute_left", mute_left, VECS[k].ml);
         check("R5 dout z after frame", int'(ser_dout === 1'bz), 1);
         prev = VECS[k].word;
      end

      // R3: codes hold mid-frame
      ser_cs_n = 1'b0;
      wait_clk(6);
      for (int b = 0; b < 8; b++) begin
         ser_din = 1'b1;
         wait_clk(HALF_BIT); ser_clk = 1'b1;
         wait_clk(HALF_BIT); ser_clk = 1'b0;
      end
      wait_clk(4);
      check("R3 mid-frame right", code_right, 8'h7F);
      check("R3 mid-frame left", code_left, 8'h80);
      for (int b = 0; b < 8; b++) begin
         ser_din = 1'b0;
         wait_clk(HALF_BIT); ser_clk = 1'b1;
         wait_clk(HALF_BIT); ser_clk = 1'b0;
      end
      wait_clk(HALF_BIT);
      ser_cs_n = 1'b1;
      wait_clk(6);
      check("R3 both update right", code_right, 8'hFF);
      check("R3 both update left", code_left, 8'h00);

      // R2: activity while deselected is ignored
      for (int b = 0; b < 10; b++) begin
         ser_din = b[0];
         wait_clk(HALF_BIT); ser_clk = 1'b1;
         wait_clk(HALF_BIT); ser_clk = 1'b0;
      end
      wait_clk(6);
      check("R2 ignore right", code_right, 8'hFF);
      check("R2 ignore left", code_left, 8'h00);
      send_frame(32'h0000_12C0, 16, rb, mid);
      check("R2 readback unchanged", rb[15:0], 16'hFF00);

      // R6 and R4: 24-clock frame keeps last 16 bits, tail echoes first byte
      send_frame(32'h00AA_3456, 24, rb, mid);
      check("R6 code_right", code_right, 8'h34);
      check("R6 code_left", code_left, 8'h56);
      check("R4 old word out", rb[23:8], 16'h12C0);
      check("R4 chained tail", rb[7:0], 8'hAA);

      // R10: short pulse ignored
      mute_n = 1'b0;
      wait_clk(HOLD - 4);
      mute_n = 1'b1;
      wait_clk(8);
      check("R10 short pulse right", mute_right, 0);
      check("R10 short pulse left", mute_left, 0);
      // R10: long low mutes both
      mute_n = 1'b0;
      wait_clk(HOLD - 2);
      check("R10 not yet", mute_right, 0);
      wait_clk(8);
      check("R10 mute right", mute_right, 1);
      check("R10 mute left", mute_left, 1);
      check("R10 code kept", code_right, 8'h34);
      mute_n = 1'b1;
      wait_clk(5);
      check("R10 release right", mute_right, 0);
      check("R10 release left", mute_left, 0);

      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      for (int c = 0; c < 150000; c++) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule